// File: doc/BRIEF.md
# Interleaved Raster Display Address Generator

This block walks a raster frame with a horizontal and a vertical scan counter and turns each scan position into video memory fetch requests for a 256×192 bitmap screen. The screen is 32 byte columns wide and 192 lines tall. Each byte column spans a fixed number of clock cycles, four by default. While the scan is inside the visible window, the block requests the pixel byte for the column in the first cycle of that column. It requests the matching colour attribute byte in the next cycle.

Bitmap bytes are not stored in simple line order. The screen is cut into three horizontal bands of 64 lines each. Inside a band, all first pixel lines of the eight character rows come first, then all second pixel lines, and so on. Attribute bytes, one for each 8×8 character cell, are stored row after row from the top. Both addresses are 15-bit offsets into a 32 KiB video RAM that holds two display banks. The most significant address bit selects the bank and comes from a bank-select input. A build option makes the bank take effect only at the start of a frame. By default the bank applies at once.

Border timing, sync generation and arbitration of the video RAM are handled outside this block.

Top module: `raster_fetch_addr`

## Requirements
- R1: While rst_n is low, hpos and vpos read 0 and active, pix_fetch and attr_fetch are all low. The reset is asynchronous, so the outputs return to these values at once when rst_n falls.
- R2: hpos rises by one every clock. It wraps from H_TOTAL-1 (223) back to 0.
- R3: vpos rises by one in the clock where hpos wraps, and holds its value otherwise. It wraps from V_TOTAL-1 (311) back to 0.
- R4: active is high exactly when vpos < 192 and hpos < 128. The byte column is hpos/4, in the range 0 to 31.
- R5: pix_fetch is high exactly in active cycles with hpos%4 == 0. attr_fetch is high exactly in active cycles with hpos%4 == 1. Neither is ever high outside the window, and the two are never high together.
- R6: Every pix_fetch is followed in the next cycle by an attr_fetch for the same byte column and line.
- R7: While pix_fetch is high, pix_addr[13:0] = 2048·(y/64) + 256·(y%8) + 32·((y/8)%8) + x, where y = vpos and x is the byte column. As bits, this is {0, y7 y6, y2 y1 y0, y5 y4 y3, x4..x0}, always below 0x1800.
- R8: While attr_fetch is high, attr_addr[13:0] = 0x1800 + 32·(y/8) + x. This lies in 0x1800 to 0x1AFF.
- R9: With the default immediate bank option, bit 14 of pix_addr and bit 14 of attr_addr equal bank_sel in the same cycle, so a bank change acts on the very next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Display bank used as address bit 14 |
| hpos | output | 8 | Horizontal scan count, in clock cycles within the line |
| vpos | output | 9 | Vertical scan count, in lines within the frame |
| active | output | 1 | Scan is inside the 32-column × 192-line window |
| pix_fetch | output | 1 | Pixel byte fetch strobe |
| attr_fetch | output | 1 | Attribute byte fetch strobe |
| pix_addr | output | 15 | Video RAM address of the pixel byte |
| attr_addr | output | 15 | Video RAM address of the attribute byte |

## Verification
Two events can fall in the same cycle: a pixel or attribute fetch and a change of bank_sel. The bench changes the bank at random moments between clock edges. It also forces a change on a fetch cycle of the last visible line. For every strobe, it checks that bit 14 of the address already carries the new bank. A line wrap and a frame wrap also coincide on the last cycle of the frame. The bench runs past that point and judges the wrap by the scan counts and by the first fetch addresses of the new frame.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

   // Fixed screen format: 32 byte columns, 192 lines, 15-bit video RAM address
   localparam int COL_W  = 5;
   localparam int LINE_W = 8;
   localparam int OFS_W  = 14;
   localparam int RAM_AW = OFS_W + 1;

   localparam logic [OFS_W-1:0] ATTR_BASE = 14'h1800;

   typedef struct packed {
      logic [LINE_W-1:0] line;
      logic [COL_W-1:0]  col;
   } cell_pos_t;

   // Bitmap offset: band, then pixel line in cell, then character row, then column
   function automatic logic [OFS_W-1:0] bitmap_offset(input cell_pos_t p);
      return {1'b0, p.line[7:6], p.line[2:0], p.line[5:3], p.col};
   endfunction

   // Attribute offset: linear character rows from the top
   function automatic logic [OFS_W-1:0] attr_offset(input cell_pos_t p);
      return {4'b0110, p.line[7:3], p.col};
   endfunction

endpackage

// File: rtl/rfa_scan_counter.sv
module rfa_scan_counter #(
   parameter int TERMINAL = 224,
   parameter int W        = $clog2(TERMINAL)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   localparam logic [W-1:0] LAST = W'(TERMINAL - 1);

   generate
      if (TERMINAL < 2) begin : g_bad_terminal
         $error("rfa_scan_counter: TERMINAL must be at least 2");
      end
      if ((1 << W) < TERMINAL) begin : g_bad_width
         $error("rfa_scan_counter: W too narrow for TERMINAL");
      end
   endgenerate

   assign wrap = step && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (step) cnt <= cnt + W'(1);
   end

   // R2 on the horizontal instance, R3 on the vertical instance
   a_r2_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wrap) |=> (cnt == W'($past(cnt) + W'(1))));
   a_r2_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
   a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt));

endmodule

// File: rtl/rfa_window.sv
module rfa_window
   import rfa_pkg::*;
#(
   parameter int H_W         = 8,
   parameter int V_W         = 9,
   parameter int COLS        = 32,
   parameter int LINES       = 192,
   parameter int CYC_PER_COL = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [H_W-1:0] hpos,
   input  logic [V_W-1:0] vpos,
   output logic           active,
   output logic           pix_fetch,
   output logic           attr_fetch,
   output cell_pos_t      pos
);

   localparam int PH_W  = $clog2(CYC_PER_COL);
   localparam int ACT_H = COLS * CYC_PER_COL;
   localparam logic [PH_W-1:0] PH_PIX  = PH_W'(0);
   localparam logic [PH_W-1:0] PH_ATTR = PH_W'(1);

   generate
      if (CYC_PER_COL < 2 || (1 << PH_W) != CYC_PER_COL) begin : g_bad_cyc
         $error("rfa_window: CYC_PER_COL must be a power of two, at least 2");
      end
      if (COLS < 1 || COLS > 32) begin : g_bad_cols
         $error("rfa_window: COLS must be 1..32");
      end
      if (LINES < 1 || LINES > 192) begin : g_bad_lines
         $error("rfa_window: LINES must be 1..192");
      end
   endgenerate

   logic [PH_W-1:0] phase;
   logic            in_h;
   logic            in_v;

   assign phase    = hpos[PH_W-1:0];
   assign pos.col  = COL_W'(hpos >> PH_W);
   assign pos.line = LINE_W'(vpos);
   assign in_h     = int'(hpos) < ACT_H;
   assign in_v     = int'(vpos) < LINES;

   assign active     = rst_n && in_h && in_v;
   assign pix_fetch  = active && (phase == PH_PIX);
   assign attr_fetch = active && (phase == PH_ATTR);

   // R1: nothing is requested while reset is held
   always_comb begin
      if (!rst_n) begin
         a_r1_quiet_in_reset: assert (!active && !pix_fetch && !attr_fetch);
      end
   end

   a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_fetch && attr_fetch));
   a_r5_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!pix_fetch && !attr_fetch));
   a_r6_attr_after_pix: assert property (@(posedge clk) disable iff (!rst_n)
      pix_fetch |=> (attr_fetch && $stable(pos)));

endmodule

// File: rtl/rfa_addr_map.sv
module rfa_addr_map
   import rfa_pkg::*;
#(
   parameter bit BANK_AT_FRAME = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              frame_start,
   input  logic              bank_sel,
   input  cell_pos_t         pos,
   output logic [RAM_AW-1:0] pix_addr,
   output logic [RAM_AW-1:0] attr_addr
);

   logic bank_eff;

   generate
      if (BANK_AT_FRAME) begin : g_bank_frame
         logic bank_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           bank_q <= 1'b0;
            else if (frame_start) bank_q <= bank_sel;
         end
         assign bank_eff = frame_start ? bank_sel : bank_q;
      end else begin : g_bank_now
         assign bank_eff = bank_sel;
      end
   endgenerate

   assign pix_addr  = {bank_eff, bitmap_offset(pos)};
   assign attr_addr = {bank_eff, attr_offset(pos)};

   a_r7_pix_in_bitmap: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (pix_addr[OFS_W-1:0] < ATTR_BASE));
   a_r8_attr_in_map: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (attr_addr[OFS_W-1:0] >= ATTR_BASE &&
                 attr_addr[OFS_W-1:0] <= 14'h1AFF));
   a_r9_banks_agree: assert property (@(posedge clk) disable iff (!rst_n)
      pix_addr[OFS_W] == attr_addr[OFS_W]);

endmodule

// File: rtl/raster_fetch_addr.sv
module raster_fetch_addr
   import rfa_pkg::*;
#(
   parameter int H_TOTAL       = 224,
   parameter int V_TOTAL       = 312,
   parameter int COLS          = 32,
   parameter int LINES         = 192,
   parameter int CYC_PER_COL   = 4,
   parameter bit BANK_AT_FRAME = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bank_sel,
   output logic [$clog2(H_TOTAL)-1:0]   hpos,
   output logic [$clog2(V_TOTAL)-1:0]   vpos,
   output logic                         active,
   output logic                         pix_fetch,
   output logic                         attr_fetch,
   output logic [14:0]                  pix_addr,
   output logic [14:0]                  attr_addr
);

   localparam int H_W = $clog2(H_TOTAL);
   localparam int V_W = $clog2(V_TOTAL);

   generate
      if (H_TOTAL < COLS * CYC_PER_COL) begin : g_bad_htotal
         $error("raster_fetch_addr: H_TOTAL shorter than the visible columns");
      end
      if (V_TOTAL < LINES) begin : g_bad_vtotal
         $error("raster_fetch_addr: V_TOTAL shorter than the visible lines");
      end
      if (RAM_AW != 15) begin : g_bad_aw
         $error("raster_fetch_addr: address format expects 15 bits");
      end
   endgenerate

   logic      h_wrap;
   logic      v_wrap;
   logic      frame_start;
   cell_pos_t pos;

   rfa_scan_counter #(.TERMINAL(H_TOTAL), .W(H_W)) i_hcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (1'b1),
      .cnt   (hpos),
      .wrap  (h_wrap)
   );

   rfa_scan_counter #(.TERMINAL(V_TOTAL), .W(V_W)) i_vcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (h_wrap),
      .cnt   (vpos),
      .wrap  (v_wrap)
   );

   rfa_window #(
      .H_W         (H_W),
      .V_W         (V_W),
      .COLS        (COLS),
      .LINES       (LINES),
      .CYC_PER_COL (CYC_PER_COL)
   ) i_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .hpos       (hpos),
      .vpos       (vpos),
      .active     (active),
      .pix_fetch  (pix_fetch),
      .attr_fetch (attr_fetch),
      .pos        (pos)
   );

   assign frame_start = (hpos == '0) && (vpos == '0);

   rfa_addr_map #(.BANK_AT_FRAME(BANK_AT_FRAME)) i_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (active),
      .frame_start (frame_start),
      .bank_sel    (bank_sel),
      .pos         (pos),
      .pix_addr    (pix_addr),
      .attr_addr   (attr_addr)
   );

   // R3: the frame wrap only happens together with a line wrap
   a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      v_wrap |=> (hpos == '0 && vpos == '0));
   // R6: the attribute fetch uses the same column as the pixel fetch before it
   a_r6_same_column: assert property (@(posedge clk) disable iff (!rst_n)
      pix_fetch |=> (attr_fetch && attr_addr[4:0] == $past(pix_addr[4:0])));

   generate
      if (!BANK_AT_FRAME) begin : g_chk_bank_now
         a_r9_bank_immediate: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_fetch || attr_fetch) |-> (pix_addr[14] == bank_sel));
      end
   endgenerate

endmodule

// File: tb/test_raster_fetch_addr.sv
`timescale 1ns/100ps
module test_raster_fetch_addr;

   localparam int HT = 224;
   localparam int VT = 312;
   localparam int CPC = 4;
   localparam int ACT_H = 32 * CPC;
   localparam int VIS = 192;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bank_sel;
   logic [7:0]  hpos;
   logic [8:0]  vpos;
   logic        active, pix_fetch, attr_fetch;
   logic [14:0] pix_addr, attr_addr;

   int checks = 0;
   int fails  = 0;
   int k      = 0;
   bit prev_pix = 1'b0;
   int prev_col = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   raster_fetch_addr i_raster_fetch_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_sel   (bank_sel),
      .hpos       (hpos),
      .vpos       (vpos),
      .active     (active),
      .pix_fetch  (pix_fetch),
      .attr_fetch (attr_fetch),
      .pix_addr   (pix_addr),
      .attr_addr  (attr_addr)
   );

   function automatic int exp_pix(int y, int x, bit b);
      return b * 16384 + 2048 * (y / 64) + 256 * (y % 8) + 32 * ((y / 8) % 8) + x;
   endfunction

   function automatic int exp_attr(int y, int x, bit b);
      return b * 16384 + 6144 + 32 * (y / 8) + x;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (k=%0d)", req, act, exp, k);
      end
   endtask

   task automatic check_reset_state();
      check("R1 hpos", int'(hpos), 0);
      check("R1 vpos", int'(vpos), 0);
      check("R1 strobes", int'({active, pix_fetch, attr_fetch}), 0);
   endtask

   task automatic check_cycle();
      int h, v, x;
      bit e_act, e_pix, e_attr;
      h = k % HT;
      v = (k / HT) % VT;
      x = h / CPC;
      e_act  = (v < VIS) && (h < ACT_H);
      e_pix  = e_act && (h % CPC == 0);
      e_attr = e_act && (h % CPC == 1);
      check("R2 hpos", int'(hpos), h);
      check("R3 vpos", int'(vpos), v);
      check("R4 active", int'(active), int'(e_act));
      check("R5 pix_fetch", int'(pix_fetch), int'(e_pix));
      check("R5 attr_fetch", int'(attr_fetch), int'(e_attr));
      if (e_pix) begin
         check("R7 pix_addr", int'(pix_addr[13:0]), exp_pix(v, x, 1'b0));
         check("R9 pix bank", int'(pix_addr[14]), int'(bank_sel));
      end
      if (e_attr) begin
         check("R8 attr_addr", int'(attr_addr[13:0]), exp_attr(v, x, 1'b0));
         check("R9 attr bank", int'(attr_addr[14]), int'(bank_sel));
         check("R6 pix before attr", int'(prev_pix), 1);
         check("R6 same column", int'(attr_addr[4:0]), prev_col);
      end
      prev_pix = pix_fetch;
      prev_col = int'(pix_addr[4:0]);
   endtask

   task automatic run_cycles(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         k++;
         @(negedge clk);
         if (($urandom % 8) == 0) bank_sel = ~bank_sel;
         // directed: bank change on a fetch cycle of the last visible line
         if ((k % HT) == 124 && ((k / HT) % VT) == VIS - 1) bank_sel = ~bank_sel;
         #0.5;
         check_cycle();
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n    = 1'b0;
      bank_sel = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #0.5;
      check_reset_state();
      rst_n = 1'b1;
      k = 0;
      prev_pix = 1'b0;
      #0.5;
      check_cycle();
      // a full frame plus the wrap into the next one
      run_cycles(HT * VT + 3 * HT);
      // asynchronous reset in the middle of a line
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      check_reset_state();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      k = 0;
      prev_pix = 1'b0;
      #0.5;
      check_cycle();
      run_cycles(3000);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule